// File: doc/BRIEF.md
# Redundant Signed-Digit Stage Chain Model

This block is a fixed-point digital stand-in for a chain of 1.5-bit pipelined conversion stages. It is meant for test environments that need realistic per-stage raw codes without an analog front end. Each stage holds a signed sample and sorts it into one of three regions using two decision levels placed symmetrically at plus and minus a quarter of the reference. It reports a 2-bit raw code for that region and passes a doubled, region-corrected residue to the following stage through a register.

The full-scale reference is `VREF = 2**(SAMPLE_W-2)`. This leaves one bit of headroom, so in-range samples lie within plus and minus VREF. Every stage works on a different sample in the same cycle. Each stage can be given fixed signed offsets on its two decision levels, which models comparator offset. The code that combines the stage codes into a final word is outside this block.

Top module: `rsd_stage_chain`

## Requirements
- R1: Stage k reports code 2'b10 when its held value is greater than `VREF/4 + HI_OFS[k]`, code 2'b00 when its held value is less than `-VREF/4 + LO_OFS[k]`, and code 2'b01 otherwise. Stage k occupies bits `[2k+1:2k]` of `stage_code`.
- R2: A held value exactly equal to either decision level is reported as the middle code 2'b01.
- R3: No stage ever reports code 2'b11.
- R4: The value passed from stage k to stage k+1 depends on the region. It is twice the held value minus VREF in the upper region, twice the held value in the middle region, and twice the held value plus VREF in the lower region.
- R5: The passed value is clamped to the range [-VREF, +VREF]. An input outside that range therefore never wraps to the opposite sign.
- R6: When `in_valid` is high at a rising edge, `stage_valid[0]` is high after that edge. `stage_valid[k+1]` equals the previous cycle's `stage_valid[k]`.
- R7: A new sample may enter on every cycle. Stage k always reports the sample that entered k cycles before stage 0 took its current one, and no sample in flight disturbs another.
- R8: While reset is applied, all `stage_valid` bits are low and every held value is zero, so every stage reports 2'b01.
- R9: A stage whose incoming valid is low keeps its held value, so its code does not change. `in_sample` has no effect while `in_valid` is low.
- R10: Nonzero `HI_OFS`/`LO_OFS` entries move the decision levels of their own stage only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Marks `in_sample` as a new sample |
| in_sample | input | SAMPLE_W | Signed two's-complement sample |
| stage_code | output | 2*NUM_STAGES | Raw code of each stage, stage k in bits [2k+1:2k] |
| stage_valid | output | NUM_STAGES | Stage k holds a newly arrived sample this cycle |

## Verification
On every cycle, the assertions check that the reserved code never appears and that the valid flag steps forward one stage per cycle. They also check that stage 0's code stays frozen when no sample arrives, and that the valid flags are clear during reset. The actual decisions need a numeric model of the residue chain, so only the bench's scenarios can show them. These decisions are the region boundaries and their tie cases, the residue arithmetic seen through downstream codes, clamping on overdriven inputs, offset thresholds and back-to-back streaming.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  typedef enum logic [1:0] {
    RSD_LOW  = 2'b00,
    RSD_MID  = 2'b01,
    RSD_HIGH = 2'b10
  } rsd_code_e;
endpackage

// File: rtl/rsd_classify.sv
// Three-way region decision against two fixed decision levels.
module rsd_classify
  import rsd_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int HI_OFS   = 0,
  parameter int LO_OFS   = 0
) (
  input  logic signed [SAMPLE_W-1:0] smp,
  output rsd_code_e                  code
);
  localparam int VREF  = 2 ** (SAMPLE_W - 2);
  localparam int TH_HI = VREF / 4 + HI_OFS;
  localparam int TH_LO = -(VREF / 4) + LO_OFS;
  localparam logic signed [SAMPLE_W+1:0] LVL_HI = (SAMPLE_W + 2)'(TH_HI);
  localparam logic signed [SAMPLE_W+1:0] LVL_LO = (SAMPLE_W + 2)'(TH_LO);

  logic signed [SAMPLE_W+1:0] smp_x;

  always_comb begin
    smp_x = {{2{smp[SAMPLE_W-1]}}, smp};
    if (smp_x > LVL_HI)      code = RSD_HIGH;
    else if (smp_x < LVL_LO) code = RSD_LOW;
    else                     code = RSD_MID;  // ties land here
  end
endmodule

// File: rtl/rsd_residue.sv
// Doubled, region-corrected residue with clamping to +/-VREF.
module rsd_residue
  import rsd_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic signed [SAMPLE_W-1:0] smp,
  input  rsd_code_e                  code,
  output logic signed [SAMPLE_W-1:0] res
);
  localparam int VREF = 2 ** (SAMPLE_W - 2);
  localparam logic signed [SAMPLE_W+1:0] VREF_P = (SAMPLE_W + 2)'(VREF);
  localparam logic signed [SAMPLE_W+1:0] VREF_N = -VREF_P;

  logic signed [SAMPLE_W+1:0] dbl, dac, wide;

  always_comb begin
    dbl = {smp[SAMPLE_W-1], smp, 1'b0};
    unique case (code)
      RSD_HIGH: dac = VREF_P;
      RSD_LOW:  dac = VREF_N;
      default:  dac = '0;
    endcase
    wide = dbl - dac;
    if (wide > VREF_P)      res = VREF_P[SAMPLE_W-1:0];
    else if (wide < VREF_N) res = VREF_N[SAMPLE_W-1:0];
    else                    res = wide[SAMPLE_W-1:0];
  end
endmodule

// File: rtl/rsd_stage.sv
// One stage: hold register with load enable, valid flag, region decision.
module rsd_stage
  import rsd_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int HI_OFS   = 0,
  parameter int LO_OFS   = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       vld_in,
  input  logic signed [SAMPLE_W-1:0] smp_in,
  output logic                       vld_o,
  output logic signed [SAMPLE_W-1:0] held_o,
  output rsd_code_e                  code_o
);
  logic signed [SAMPLE_W-1:0] held_q, held_d;
  logic                       vld_q, vld_d;

  always_comb begin
    held_d = held_q;
    if (vld_in) held_d = smp_in;
    vld_d = vld_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      held_q <= held_d;
      vld_q  <= vld_d;
    end
  end

  rsd_classify #(
    .SAMPLE_W(SAMPLE_W),
    .HI_OFS  (HI_OFS),
    .LO_OFS  (LO_OFS)
  ) u_cls (
    .smp (held_q),
    .code(code_o)
  );

  assign vld_o  = vld_q;
  assign held_o = held_q;
endmodule

// File: rtl/rsd_stage_chain.sv
module rsd_stage_chain
  import rsd_pkg::*;
#(
  parameter int NUM_STAGES           = 4,
  parameter int SAMPLE_W             = 12,
  parameter int HI_OFS [NUM_STAGES]  = '{default: 0},
  parameter int LO_OFS [NUM_STAGES]  = '{default: 0}
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  output logic [2*NUM_STAGES-1:0]    stage_code,
  output logic [NUM_STAGES-1:0]      stage_valid
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic signed [SAMPLE_W-1:0] link_smp  [NUM_STAGES];
  logic                       link_vld  [NUM_STAGES];
  logic signed [SAMPLE_W-1:0] held      [NUM_STAGES];
  rsd_code_e                  code      [NUM_STAGES];

  assign link_smp[0] = in_sample;
  assign link_vld[0] = in_valid;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    logic vld;

    rsd_stage #(
      .SAMPLE_W(SAMPLE_W),
      .HI_OFS  (HI_OFS[g]),
      .LO_OFS  (LO_OFS[g])
    ) u_stage (
      .clk   (clk),
      .rst_n (rst_core_n),
      .vld_in(link_vld[g]),
      .smp_in(link_smp[g]),
      .vld_o (vld),
      .held_o(held[g]),
      .code_o(code[g])
    );

    assign stage_valid[g]      = vld;
    assign stage_code[2*g +: 2] = code[g];

    if (g < NUM_STAGES - 1) begin : g_next
      rsd_residue #(.SAMPLE_W(SAMPLE_W)) u_res (
        .smp (held[g]),
        .code(code[g]),
        .res (link_smp[g+1])
      );
      assign link_vld[g+1] = vld;
    end
  end
endmodule

// File: rtl/rsd_chain_checker.sv
module rsd_chain_checker #(
  parameter int NUM_STAGES = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [2*NUM_STAGES-1:0] stage_code,
  input logic [NUM_STAGES-1:0]   stage_valid
);
  always @(posedge clk) begin
    if (!rst_n) AST_RESET_CLEAR: assert (stage_valid == '0); // R8
  end

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_code
    AST_NO_RESERVED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      stage_code[2*g +: 2] != 2'b11); // R3
  end

  AST_FIRST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (stage_valid[0] == $past(in_valid))); // R6

  for (genvar g = 0; g < NUM_STAGES - 1; g++) begin : g_vld
    AST_VALID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (stage_valid[g+1] == $past(stage_valid[g]))); // R6
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(stage_code[1:0])); // R9
endmodule

bind rsd_stage_chain rsd_chain_checker #(.NUM_STAGES(NUM_STAGES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .in_valid   (in_valid),
  .stage_code (stage_code),
  .stage_valid(stage_valid)
);

// File: tb/tb_rsd_stage_chain.sv
`timescale 1ns/1ps
module tb_rsd_stage_chain;
  localparam int NS   = 4;
  localparam int W    = 12;
  localparam int VREF = 2 ** (W - 2);

  logic clk, rst_n, in_valid;
  logic signed [W-1:0] in_sample;
  logic [2*NS-1:0] code_a, code_b;
  logic [NS-1:0]   vld_a, vld_b;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  rsd_stage_chain #(.NUM_STAGES(NS), .SAMPLE_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .stage_code(code_a), .stage_valid(vld_a));

  rsd_stage_chain #(.NUM_STAGES(NS), .SAMPLE_W(W),
    .HI_OFS('{40, 0, 0, 0}), .LO_OFS('{-30, 0, 0, 0})) dut_ofs (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .stage_code(code_b), .stage_valid(vld_b));

  function automatic int lvl_hi(int j, bit ofs);
    return VREF / 4 + ((ofs && j == 0) ? 40 : 0);
  endfunction

  function automatic int lvl_lo(int j, bit ofs);
    return -(VREF / 4) + ((ofs && j == 0) ? -30 : 0);
  endfunction

  // Expected code of stage k for input x0, from the requirements.
  function automatic int model_code(int x0, int k, bit ofs);
    int x = x0;
    int c = 1;
    for (int j = 0; j <= k; j++) begin
      if (x > lvl_hi(j, ofs))      c = 2;
      else if (x < lvl_lo(j, ofs)) c = 0;
      else                         c = 1;
      if (j == k) break;
      x = 2 * x - (c - 1) * VREF;
      if (x > VREF)  x = VREF;
      if (x < -VREF) x = -VREF;
    end
    return c;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req, int x);
    for (int k = 0; k < NS; k++) begin
      check(req, $sformatf("nominal stage %0d x=%0d", k, x),
            int'(code_a[2*k +: 2]), model_code(x, k, 1'b0));
      check(req, $sformatf("offset stage %0d x=%0d", k, x),
            int'(code_b[2*k +: 2]), model_code(x, k, 1'b1));
    end
  endtask

  // One sample, then let it settle through every stage.
  task automatic apply_one(int x);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = W'(x);
    @(negedge clk);
    in_valid  = 1'b0;
    repeat (NS) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R8", "valid during reset", int'(vld_a), 0);
    for (int k = 0; k < NS; k++)
      check("R8", $sformatf("code stage %0d in reset", k), int'(code_a[2*k +: 2]), 1);
  endtask

  task automatic t_regions();  // R1, R4
    int xs[6] = '{700, -700, 100, -100, 900, -300};
    foreach (xs[i]) begin
      apply_one(xs[i]);
      check_all("R1_R4", xs[i]);
    end
    apply_one(1);
    check("R1", "no decision at zero, +1", int'(code_a[1:0]), 1);
    apply_one(-1);
    check("R1", "no decision at zero, -1", int'(code_a[1:0]), 1);
  endtask

  task automatic t_ties();  // R2
    apply_one(VREF / 4);
    check("R2", "tie at upper level", int'(code_a[1:0]), 1);
    check_all("R2", VREF / 4);
    apply_one(-(VREF / 4));
    check("R2", "tie at lower level", int'(code_a[1:0]), 1);
    check_all("R2", -(VREF / 4));
    apply_one(VREF / 4 + 1);
    check("R2", "just above upper level", int'(code_a[1:0]), 2);
  endtask

  task automatic t_saturate();  // R5
    int xs[3] = '{3 * VREF / 2, -3 * VREF / 2, -2 * VREF};
    foreach (xs[i]) begin
      apply_one(xs[i]);
      check_all("R5", xs[i]);
    end
    apply_one(3 * VREF / 2);
    check("R5", "last stage after overdrive", int'(code_a[2*(NS-1) +: 2]), 2);
  endtask

  task automatic t_valid_walk();  // R6
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = W'(200);
    for (int m = 1; m <= NS + 1; m++) begin
      @(negedge clk);
      in_valid = 1'b0;
      check("R6", $sformatf("valid pattern after %0d edges", m),
            int'(vld_a), (m <= NS) ? (1 << (m - 1)) : 0);
    end
  endtask

  task automatic t_stream();  // R7, R3
    int s[8] = '{700, -700, 256, -256, 5, 1000, -1000, 300};
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = W'(s[0]);
    for (int p = 0; p < 8 + NS - 1; p++) begin
      @(negedge clk);
      for (int k = 0; k < NS; k++) begin
        int idx = p - k;
        if (idx >= 0 && idx < 8) begin
          check("R7", $sformatf("stream valid p=%0d k=%0d", p, k), int'(vld_a[k]), 1);
          check("R7", $sformatf("stream code p=%0d k=%0d", p, k),
                int'(code_a[2*k +: 2]), model_code(s[idx], k, 1'b0));
          check("R7", $sformatf("stream offset code p=%0d k=%0d", p, k),
                int'(code_b[2*k +: 2]), model_code(s[idx], k, 1'b1));
        end else begin
          check("R7", $sformatf("stream idle p=%0d k=%0d", p, k), int'(vld_a[k]), 0);
        end
        checks++;
        if (code_a[2*k +: 2] == 2'b11) begin
          errors++;
          $display("FAIL R3 reserved code stage %0d: actual 3 expected not 3", k);
        end
      end
      if (p + 1 < 8) in_sample = W'(s[p + 1]);
      else           in_valid  = 1'b0;
    end
    in_valid = 1'b0;
  endtask

  task automatic t_hold();  // R9
    apply_one(700);
    in_sample = W'(-900);
    repeat (3) @(negedge clk);
    check("R9", "valid low while idle", int'(vld_a), 0);
    check_all("R9", 700);
  endtask

  task automatic t_offsets();  // R10
    apply_one(270);
    check("R10", "nominal upper region", int'(code_a[1:0]), 2);
    check("R10", "shifted upper level keeps middle", int'(code_b[1:0]), 1);
    check_all("R10", 270);
    apply_one(-270);
    check("R10", "nominal lower region", int'(code_a[1:0]), 0);
    check("R10", "shifted lower level keeps middle", int'(code_b[1:0]), 1);
    check_all("R10", -270);
    apply_one(600);
    check("R10", "stage 1 unshifted", int'(code_b[3:2]), model_code(600, 1, 1'b0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_sample = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_regions();
    t_ties();
    t_saturate();
    t_valid_walk();
    t_stream();
    t_hold();
    t_offsets();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule